// File: doc/BRIEF.md
# AXI4 Write Channel Monitor

This block sits beside one AXI4 write port and only listens. It watches the address, data and response channels and raises sticky error flags when the traffic breaks the write-burst rules. It drives no handshake signal and has no effect on the port it observes. A data beat counts only when both sides of the data channel agree in the same cycle. Each burst's beat total is checked against the length declared on the address channel, and every write response is checked against a burst that has already finished.

Addresses and data bursts may arrive in either order. The monitor therefore keeps two small queues. One holds accepted burst lengths. The other holds the beat totals of finished data bursts. The two heads are paired in arrival order. A correctly paired burst becomes eligible for exactly one response. The first error seen is reported as a 3-bit code. A 16-bit counter reports how many bursts completed cleanly.

Top module: `axi_wr_monitor`

## Requirements
- R1: A data beat is counted only in a cycle where `w_valid` and `w_ready` are both high. A cycle with either low changes no count and does not end a burst, even when `w_last` is high.
- R2: A data burst must end with `w_last` on the beat whose zero-based index equals its `aw_len`, giving `aw_len`+1 beats. An early or late `w_last` sets flag bit 0 and code 1 (length).
- R3: Address and data bursts may arrive in either order or in the same cycle. They are paired oldest-first, and a burst whose address and final beat both happened by cycle t may be answered from cycle t+1.
- R4: A response that starts (`b_valid` high while no response was being held) with no eligible burst is premature. It sets flag bit 1 and code 2 (response).
- R5: A second response for an already-answered burst sets flag bit 1 and code 2.
- R6: Once `b_valid` is high without `b_ready`, it must stay high with `b_resp` unchanged in the next cycle. Otherwise flag bit 2 and code 3 (hold) are set.
- R7: Bursts of up to 256 beats (`aw_len` = 255) are accepted. A 256th beat without `w_last` sets flag bit 0 and code 1.
- R8: More than four unpaired addresses or four unpaired data bursts set flag bit 3 and code 4 (capacity).
- R9: Flags are sticky and `err_code` keeps the first error's code (0 = none; the lowest code wins on a tie). Both clear only on the active-low synchronous reset.
- R10: `burst_count` rises by one for each burst whose length matched, and it is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| aw_valid | input | 1 | Address channel valid |
| aw_ready | input | 1 | Address channel ready |
| aw_len | input | 8 | Burst length minus one |
| w_valid | input | 1 | Data channel valid |
| w_ready | input | 1 | Data channel ready |
| w_last | input | 1 | Final beat marker |
| b_valid | input | 1 | Response valid |
| b_ready | input | 1 | Response ready |
| b_resp | input | 2 | Response status |
| err_flags | output | 4 | Sticky flags: bit0 length, bit1 response, bit2 hold, bit3 capacity |
| err_code | output | 3 | First error code, 0 when clean |
| burst_count | output | 16 | Count of correctly completed bursts |

## Verification
The checker properties assume that the reset is low for the first clock edges and that every input is a known value at each edge. The assertions on flags and codes make no assumption about legal protocol, because breaking the protocol is the stimulus. The bench drives all inputs on the falling edge. It holds reset from time zero and produces each violation on purpose in an isolated run, so the first-error code it expects is the one it provoked. The longest window it opens is a 256-beat burst. That window fits well inside the queues and the pending counter, except in the capacity test, which is meant to overflow them.

// File: rtl/axi_wmon_pkg.sv
// Package: shared error encoding for the AXI4 write monitor.
// Assumes: codes are 1-based and flag bit i corresponds to code i+1.
package axi_wmon_pkg;
    typedef enum logic [2:0] {
        CODE_NONE = 3'd0,
        CODE_LEN  = 3'd1,
        CODE_RESP = 3'd2,
        CODE_HOLD = 3'd3,
        CODE_CAP  = 3'd4
    } err_code_e;

    localparam int NUM_ERR = 4;
    localparam int BIT_LEN  = 0;
    localparam int BIT_RESP = 1;
    localparam int BIT_HOLD = 2;
    localparam int BIT_CAP  = 3;
endpackage

// File: rtl/wmon_fifo.sv
// Module: small synchronous queue holding burst descriptors in order.
// Assumes: a push into a full queue is dropped unless a pop frees a slot
// in the same cycle; the dropped push is reported on overflow.
module wmon_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full,
    output logic             overflow
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] cnt;
    logic             do_push, do_pop;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign empty    = (cnt == '0);
    assign full     = (cnt == CNT_W'(DEPTH));
    assign do_pop   = pop && !empty;
    assign do_push  = push && (!full || do_pop);
    assign overflow = push && full && !do_pop;
    assign dout     = mem[rd_ptr];

    // Store the pushed entry at the write slot.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= ptr_inc(wr_ptr);
            if (do_pop)  rd_ptr <= ptr_inc(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + CNT_W'(1);
                2'b01:   cnt <= cnt - CNT_W'(1);
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/wmon_beat_counter.sv
// Module: counts handshaken data beats and reports each finished burst.
// Assumes: w_hs is already the valid-and-ready product; a burst that
// reaches the maximum length without a last marker is reported as overrun
// and counting restarts.
module wmon_beat_counter #(
    parameter int LEN_W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           w_hs,
    input  logic           w_last,
    output logic           done,
    output logic [LEN_W:0] beats,
    output logic           overrun
);
    logic [LEN_W-1:0] cnt_q;
    logic             at_max;

    assign at_max  = (cnt_q == '1);
    assign beats   = {1'b0, cnt_q} + (LEN_W + 1)'(1);
    assign done    = w_hs && w_last;
    assign overrun = w_hs && !w_last && at_max;

    // Track beats accepted so far in the current burst.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (done || overrun)    cnt_q <= '0;
        else if (w_hs)               cnt_q <= cnt_q + LEN_W'(1);
    end
endmodule

// File: rtl/wmon_resp_tracker.sv
// Module: tracks bursts eligible for a response and checks the response
// channel hold rule.
// Assumes: match_good pulses once per correctly paired burst; a burst
// paired in the current cycle may be answered in that same cycle.
module wmon_resp_tracker #(
    parameter int PEND_W = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       match_good,
    input  logic       b_valid,
    input  logic       b_ready,
    input  logic [1:0] b_resp,
    output logic       resp_err,
    output logic       hold_err,
    output logic       pend_ovf
);
    localparam int PW1 = PEND_W + 1;

    logic [PEND_W-1:0] pend_q;
    logic [PW1-1:0]    pend_eff, pend_nxt;
    logic              hold_q;
    logic [1:0]        resp_q;
    logic              b_start, b_hs, dec;

    assign b_start  = b_valid && !hold_q;
    assign b_hs     = b_valid && b_ready;
    assign pend_eff = {1'b0, pend_q} + PW1'(match_good);
    assign resp_err = b_start && (pend_eff == '0);
    assign dec      = b_hs && (pend_eff != '0);
    assign pend_nxt = pend_eff - PW1'(dec);
    assign pend_ovf = pend_nxt[PEND_W];
    assign hold_err = hold_q && (!b_valid || (b_resp != resp_q));

    // Count eligible bursts, saturating on overflow.
    always_ff @(posedge clk) begin
        if (!rst_n)        pend_q <= '0;
        else if (pend_ovf) pend_q <= '1;
        else               pend_q <= pend_nxt[PEND_W-1:0];
    end

    // Remember a response that is waiting to be accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
            resp_q <= 2'b00;
        end else begin
            hold_q <= b_valid && !b_ready;
            resp_q <= b_resp;
        end
    end
endmodule

// File: rtl/axi_wr_monitor.sv
// Module: passive AXI4 write-port protocol monitor (top).
// Assumes: inputs are the raw channel signals of one write port with no
// IDs; it never drives the port. Addresses and data bursts are paired
// oldest-first through two queues; errors are sticky until reset.
module axi_wr_monitor
    import axi_wmon_pkg::*;
#(
    parameter int LEN_W    = 8,
    parameter int AW_DEPTH = 4,
    parameter int W_DEPTH  = 4,
    parameter int PEND_W   = 4,
    parameter int CNT_W    = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               aw_valid,
    input  logic               aw_ready,
    input  logic [LEN_W-1:0]   aw_len,
    input  logic               w_valid,
    input  logic               w_ready,
    input  logic               w_last,
    input  logic               b_valid,
    input  logic               b_ready,
    input  logic [1:0]         b_resp,
    output logic [NUM_ERR-1:0] err_flags,
    output logic [2:0]         err_code,
    output logic [CNT_W-1:0]   burst_count
);
    localparam int BEAT_W = LEN_W + 1;

    logic              aw_hs, w_hs;
    logic [LEN_W-1:0]  aw_head;
    logic [BEAT_W-1:0] w_head, w_beats;
    logic              aw_empty, aw_full, aw_ovf;
    logic              w_empty, w_full, w_ovf;
    logic              w_done, w_overrun;
    logic              match, match_good;
    logic              resp_err, hold_err, pend_ovf;
    logic [NUM_ERR-1:0] new_err, flags_q;
    err_code_e         code_q, first_code;
    logic [CNT_W-1:0]  count_q;

    assign aw_hs = aw_valid && aw_ready;
    assign w_hs  = w_valid && w_ready;

    wmon_fifo #(.WIDTH(LEN_W), .DEPTH(AW_DEPTH)) u_aw_q (
        .clk(clk), .rst_n(rst_n), .push(aw_hs), .din(aw_len), .pop(match),
        .dout(aw_head), .empty(aw_empty), .full(aw_full), .overflow(aw_ovf)
    );

    wmon_beat_counter #(.LEN_W(LEN_W)) u_beats (
        .clk(clk), .rst_n(rst_n), .w_hs(w_hs), .w_last(w_last),
        .done(w_done), .beats(w_beats), .overrun(w_overrun)
    );

    wmon_fifo #(.WIDTH(BEAT_W), .DEPTH(W_DEPTH)) u_w_q (
        .clk(clk), .rst_n(rst_n), .push(w_done), .din(w_beats), .pop(match),
        .dout(w_head), .empty(w_empty), .full(w_full), .overflow(w_ovf)
    );

    // Pair the oldest address with the oldest finished data burst.
    assign match      = !aw_empty && !w_empty;
    assign match_good = match && (w_head == ({1'b0, aw_head} + BEAT_W'(1)));

    wmon_resp_tracker #(.PEND_W(PEND_W)) u_resp (
        .clk(clk), .rst_n(rst_n), .match_good(match_good),
        .b_valid(b_valid), .b_ready(b_ready), .b_resp(b_resp),
        .resp_err(resp_err), .hold_err(hold_err), .pend_ovf(pend_ovf)
    );

    // Gather this cycle's violations into flag positions.
    always_comb begin
        new_err           = '0;
        new_err[BIT_LEN]  = (match && !match_good) || w_overrun;
        new_err[BIT_RESP] = resp_err;
        new_err[BIT_HOLD] = hold_err;
        new_err[BIT_CAP]  = aw_ovf || w_ovf || pend_ovf;
    end

    // Pick the lowest-numbered code among simultaneous violations.
    always_comb begin
        first_code = CODE_NONE;
        for (int i = NUM_ERR - 1; i >= 0; i--) begin
            if (new_err[i]) first_code = err_code_e'(3'(i + 1));
        end
    end

    // Keep sticky flags and the first error code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            code_q  <= CODE_NONE;
        end else begin
            flags_q <= flags_q | new_err;
            if (code_q == CODE_NONE) code_q <= first_code;
        end
    end

    // Count bursts whose length matched.
    always_ff @(posedge clk) begin
        if (!rst_n)          count_q <= '0;
        else if (match_good) count_q <= count_q + CNT_W'(1);
    end

    assign err_flags   = flags_q;
    assign err_code    = code_q;
    assign burst_count = count_q;
endmodule

// File: rtl/axi_wr_monitor_checker.sv
// Module: assertion checker bound to the write monitor.
// Assumes: reset is low at the first edges and inputs are known values.
module axi_wr_monitor_checker #(
    parameter int NERR  = 4,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             b_valid,
    input logic             b_ready,
    input logic [NERR-1:0]  err_flags,
    input logic [2:0]       err_code,
    input logic [CNT_W-1:0] burst_count
);
    // R9: no flag ever clears while out of reset
    a_r9_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flags & $past(err_flags)) == $past(err_flags));

    // R9: a recorded code never changes
    a_r9_code_held: assert property (@(posedge clk) disable iff (!rst_n)
        (err_code != 3'd0) |=> $stable(err_code));

    // R9: a code is present exactly when some flag is set
    a_r9_code_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (err_code == 3'd0) == (err_flags == '0));

    // R10: the completed-burst count steps by at most one
    a_r10_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_count - $past(burst_count)) <= CNT_W'(1));

    // R6: a response dropped before acceptance is flagged next cycle
    a_r6_drop_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(b_valid && !b_ready) && !b_valid) |=> err_flags[2]);
endmodule

bind axi_wr_monitor axi_wr_monitor_checker #(
    .NERR(axi_wmon_pkg::NUM_ERR), .CNT_W(CNT_W)
) u_checker (
    .clk(clk), .rst_n(rst_n), .b_valid(b_valid), .b_ready(b_ready),
    .err_flags(err_flags), .err_code(err_code), .burst_count(burst_count)
);

// File: tb/axi_wr_monitor_tb.sv
`timescale 1ns/1ps
module axi_wr_monitor_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        aw_valid = 0, aw_ready = 1, w_valid = 0, w_ready = 1, w_last = 0;
    logic        b_valid = 0, b_ready = 0;
    logic [7:0]  aw_len = '0;
    logic [1:0]  b_resp = '0;
    logic [3:0]  err_flags;
    logic [2:0]  err_code;
    logic [15:0] burst_count;

    int n_checks = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    axi_wr_monitor u_dut (
        .clk(clk), .rst_n(rst_n), .aw_valid(aw_valid), .aw_ready(aw_ready),
        .aw_len(aw_len), .w_valid(w_valid), .w_ready(w_ready), .w_last(w_last),
        .b_valid(b_valid), .b_ready(b_ready), .b_resp(b_resp),
        .err_flags(err_flags), .err_code(err_code), .burst_count(burst_count)
    );

    // Vector fields: [23:22] order (0 addr first, 1 data first, 2 same cycle),
    // [21:14] len, [13:5] beats, [4] stall, [3:1] expected code, [0] expected count
    localparam logic [23:0] VEC [8] = '{
        {2'd0, 8'd0,  9'd1,  1'b0, 3'd0, 1'b1},
        {2'd0, 8'd3,  9'd4,  1'b1, 3'd0, 1'b1},
        {2'd1, 8'd3,  9'd4,  1'b0, 3'd0, 1'b1},
        {2'd2, 8'd7,  9'd8,  1'b1, 3'd0, 1'b1},
        {2'd0, 8'd3,  9'd3,  1'b0, 3'd1, 1'b0},
        {2'd1, 8'd1,  9'd3,  1'b0, 3'd1, 1'b0},
        {2'd2, 8'd15, 9'd16, 1'b0, 3'd0, 1'b1},
        {2'd1, 8'd0,  9'd1,  1'b1, 3'd0, 1'b1}
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 0; aw_valid = 0; w_valid = 0; w_last = 0; b_valid = 0; b_ready = 0;
        aw_ready = 1; w_ready = 1; b_resp = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic send_aw(input int len);
        aw_valid = 1; aw_len = 8'(len);
        @(negedge clk);
        aw_valid = 0;
    endtask

    task automatic send_w(input int n, input bit stall, input bit with_last);
        for (int i = 0; i < n; i++) begin
            if (stall && (i % 2 == 1)) begin
                w_valid = 1; w_ready = 0; w_last = with_last && (i == n - 1);
                @(negedge clk);
                aw_valid = 0;
            end
            w_valid = 1; w_ready = 1; w_last = with_last && (i == n - 1);
            @(negedge clk);
            aw_valid = 0;
        end
        w_valid = 0; w_last = 0;
    endtask

    task automatic send_b(input int wait_cycles);
        b_valid = 1; b_ready = 0;
        repeat (wait_cycles) @(negedge clk);
        b_ready = 1;
        @(negedge clk);
        b_valid = 0; b_ready = 0;
    endtask

    task automatic good_burst(input int len);
        send_aw(len);
        send_w(len + 1, 0, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        do_reset();
        // R9 R10: reset state
        chk("R9", "reset code", int'(err_code), 0);
        chk("R9", "reset flags", int'(err_flags), 0);
        chk("R10", "reset count", int'(burst_count), 0);

        // R2 R3: vector table over order, length, stalls
        for (int v = 0; v < 8; v++) begin
            automatic logic [23:0] e = VEC[v];
            do_reset();
            case (e[23:22])
                2'd0: begin send_aw(int'(e[21:14])); send_w(int'(e[13:5]), e[4], 1); end
                2'd1: begin send_w(int'(e[13:5]), e[4], 1); send_aw(int'(e[21:14])); end
                default: begin aw_valid = 1; aw_len = e[21:14]; send_w(int'(e[13:5]), e[4], 1); end
            endcase
            send_b(1);
            repeat (2) @(negedge clk);
            chk(e[3:1] == 0 ? "R3" : "R2", $sformatf("vec %0d code", v), int'(err_code), int'(e[3:1]));
            chk("R10", $sformatf("vec %0d count", v), int'(burst_count), int'(e[0]));
        end

        // R1: non-handshake cycles with w_last high are ignored
        do_reset();
        w_valid = 1; w_ready = 0; w_last = 1; @(negedge clk);
        w_valid = 0; w_ready = 1; w_last = 1; @(negedge clk);
        w_last = 0;
        good_burst(1);
        send_b(0);
        repeat (2) @(negedge clk);
        chk("R1", "ignored beats code", int'(err_code), 0);
        chk("R1", "ignored beats count", int'(burst_count), 1);

        // R4: response with no burst
        do_reset();
        send_b(0);
        @(negedge clk);
        chk("R4", "premature code", int'(err_code), 2);
        chk("R4", "premature flag", int'(err_flags), 2);

        // R5: duplicate response
        do_reset();
        good_burst(2);
        send_b(0);
        @(negedge clk);
        chk("R5", "single response clean", int'(err_code), 0);
        send_b(0);
        @(negedge clk);
        chk("R5", "duplicate code", int'(err_code), 2);
        chk("R5", "duplicate count", int'(burst_count), 1);

        // R6: response dropped before ready
        do_reset();
        good_burst(0);
        b_valid = 1; b_ready = 0; @(negedge clk);
        b_valid = 0; @(negedge clk);
        @(negedge clk);
        chk("R6", "drop code", int'(err_code), 3);
        chk("R6", "drop flag", int'(err_flags[2]), 1);

        // R6: status changed while waiting
        do_reset();
        good_burst(0);
        b_valid = 1; b_ready = 0; b_resp = 2'd0; @(negedge clk);
        b_resp = 2'd2; @(negedge clk);
        b_ready = 1; @(negedge clk);
        b_valid = 0; b_ready = 0; b_resp = 0;
        @(negedge clk);
        chk("R6", "status change code", int'(err_code), 3);

        // R7: full 256-beat burst
        do_reset();
        good_burst(255);
        send_b(0);
        repeat (2) @(negedge clk);
        chk("R7", "256 beats code", int'(err_code), 0);
        chk("R7", "256 beats count", int'(burst_count), 1);

        // R7: 256th beat without last
        do_reset();
        send_aw(255);
        send_w(256, 0, 0);
        @(negedge clk);
        chk("R7", "missing last code", int'(err_code), 1);
        chk("R7", "missing last flag", int'(err_flags[0]), 1);

        // R8: five unpaired addresses
        do_reset();
        for (int k = 0; k < 5; k++) send_aw(k);
        @(negedge clk);
        chk("R8", "capacity code", int'(err_code), 4);
        chk("R8", "capacity flag", int'(err_flags[3]), 1);

        // R3: two addresses ahead of their data, paired in order
        do_reset();
        send_aw(1);
        send_aw(2);
        send_w(2, 0, 1);
        send_w(3, 1, 1);
        send_b(0);
        send_b(2);
        repeat (2) @(negedge clk);
        chk("R3", "in-order pairing code", int'(err_code), 0);
        chk("R10", "two bursts count", int'(burst_count), 2);

        // R9: first code kept, then cleared by reset
        send_b(0);
        good_burst(0);
        b_valid = 1; b_ready = 0; @(negedge clk);
        b_valid = 0; @(negedge clk);
        @(negedge clk);
        chk("R9", "first code kept", int'(err_code), 2);
        chk("R9", "later flag added", int'(err_flags), 6);
        do_reset();
        chk("R9", "cleared code", int'(err_code), 0);
        chk("R9", "cleared flags", int'(err_flags), 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule